// File: doc/BRIEF.md
# Interrupt Acceptance and Mask Unit

This unit sits beside a processor core and decides, every cycle, whether the core should take an interrupt now. It sees a set of maskable requests, each with its own 4-bit priority, and a non-maskable pin that is active on its falling edge. It keeps the core's block flag and current mask level as shadow registers. Software loads these registers through two write ports, and the unit also updates them by itself whenever it accepts an interrupt.

When a request is taken, the unit raises a one-cycle accept pulse. It also registers two values: an event code that software can use directly as an offset into a table of per-source handlers, and the level that was accepted. An optional automatic mode raises the mask level to the accepted level, so that only more urgent work can nest once software clears the block flag. An extra masking rule, tied to the level of the non-maskable pin, silences maskable requests while the pin is low. In standby it also silences the non-maskable interrupt and the wake request.

Top module: `irq_accept_unit`

## Requirements
- R1: After synchronous reset, the accept pulse and wake request are 0, the mask level reads 15 and the block state reads 1.
- R2: While the block state is 1, no maskable request is accepted.
- R3: A maskable request is accepted only if its level is strictly greater than the current mask level, so a level-0 request is never accepted.
- R4: Among eligible maskable requests the highest level wins, and on equal levels the lowest source index wins.
- R5: The event code is 0x200 + 0x20 × source index for maskable sources and 0x1C0 for the non-maskable interrupt. The accepted level reads 16 for the non-maskable interrupt.
- R6: Every acceptance sets the block state to 1. With automatic update enabled, the mask level becomes the accepted level, limited to 15. With it disabled, the mask level is unchanged.
- R7: In normal mode (pmode 00) and sleep mode (pmode 01), while the NMI-level mask enable is 1 and the non-maskable pin is low, no maskable request is accepted. Once the pin is high again, requests are accepted normally.
- R8: A falling edge on the non-maskable pin makes it pending. A pending non-maskable interrupt is accepted on the next clock edge in normal or sleep mode, whatever the block state, mask level or NMI-level mask enable. It is accepted once, and the pending state then clears.
- R9: In standby mode (pmode 10) nothing is accepted. The wake request goes to 1 when the non-maskable interrupt is pending or a maskable request is eligible. While the NMI-level mask enable is 1 and the pin is low, the wake request stays 0.
- R10: The event code and accepted level hold their values until the next acceptance.
- R11: The mask and block write ports take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | N_SRC | Maskable request per source |
| req_lvl | input | 4*N_SRC | Priority level per source, source i in bits 4i+3:4i |
| nmi_pin | input | 1 | Non-maskable pin, falling-edge active |
| auto_en | input | 1 | Mask level follows the accepted level |
| mai_en | input | 1 | NMI-level mask enable |
| pmode | input | 2 | 00 normal, 01 sleep, 10 standby, 11 as normal |
| mask_we | input | 1 | Write strobe for the mask level |
| mask_wd | input | 4 | Mask level write data |
| blk_we | input | 1 | Write strobe for the block state |
| blk_wd | input | 1 | Block state write data |
| acc_pulse | output | 1 | One-cycle acceptance pulse |
| acc_code | output | 12 | Event code of the last accepted interrupt |
| acc_level | output | 5 | Level of the last accepted interrupt |
| mask_lvl | output | 4 | Current mask level |
| blk_state | output | 1 | Current block state |
| wake_req | output | 1 | Standby wake request |

## Verification
A maskable acceptance, with its code, level and updated mask, appears one clock edge after the request is presented. A non-maskable acceptance appears two edges after the pin falls: one edge to latch the pending flag and one to accept it. The wake request follows its condition by one edge, which is two edges after a pin fall. The driver records the cycle in which each acceptance is due. The monitor samples on falling edges and compares each pulse against that cycle and those values. A pulse with no matching entry fails, and so does an entry that goes past its due cycle without a pulse.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

  localparam int LVL_W  = 4;
  localparam int ALVL_W = 5;
  localparam int CODE_W = 12;
  localparam logic [ALVL_W-1:0] NMI_LEVEL = 5'd16;

  typedef enum logic [1:0] {
    PM_RUN  = 2'b00,
    PM_DOZE = 2'b01,
    PM_DEEP = 2'b10,
    PM_RSVD = 2'b11
  } pmode_e;

  // Handler offset for a maskable source.
  function automatic logic [CODE_W-1:0] src_code(input int base, input int step, input int idx);
    return CODE_W'(base + idx * step);
  endfunction

  // Mask level after an acceptance.
  function automatic logic [LVL_W-1:0] mask_after(input logic auto_upd,
                                                  input logic [ALVL_W-1:0] lvl,
                                                  input logic [LVL_W-1:0] cur);
    if (!auto_upd) return cur;
    if (lvl > ALVL_W'(15)) return LVL_W'(15);
    return lvl[LVL_W-1:0];
  endfunction

endpackage

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic take,
  output logic pend,
  output logic fall
);
  logic pin_q;

  assign fall = pin_q & ~pin;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b1;
      pend  <= 1'b0;
    end else begin
      pin_q <= pin;
      if (fall)      pend <= 1'b1;
      else if (take) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_SRC = 8,
  parameter int LW    = 4,
  localparam int IW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]    vld,
  input  logic [N_SRC*LW-1:0] lvls,
  input  logic [LW-1:0]       mask,
  input  logic                allow,
  output logic                hit,
  output logic [IW-1:0]       idx,
  output logic [LW-1:0]       lvl
);
  logic [N_SRC-1:0] cand;

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_cand
      assign cand[g] = allow & vld[g] & (lvls[g*LW +: LW] > mask);
    end
  endgenerate

  // Strictly-greater replacement keeps the lowest index on ties.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    lvl = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (cand[i] && (!hit || lvls[i*LW +: LW] > lvl)) begin
        hit = 1'b1;
        idx = IW'(i);
        lvl = lvls[i*LW +: LW];
      end
    end
  end
endmodule

// File: rtl/irq_accept_state.sv
module irq_accept_state
  import irq_accept_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [CODE_W-1:0] take_code,
  input  logic [ALVL_W-1:0] take_lvl,
  input  logic              auto_en,
  input  logic              mask_we,
  input  logic [LVL_W-1:0]  mask_wd,
  input  logic              blk_we,
  input  logic              blk_wd,
  input  logic              wake_nx,
  output logic              acc_pulse,
  output logic [CODE_W-1:0] acc_code,
  output logic [ALVL_W-1:0] acc_level,
  output logic [LVL_W-1:0]  mask_q,
  output logic              blk_q,
  output logic              wake_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_pulse <= 1'b0;
      acc_code  <= '0;
      acc_level <= '0;
      mask_q    <= LVL_W'(15);
      blk_q     <= 1'b1;
      wake_q    <= 1'b0;
    end else begin
      acc_pulse <= take;
      wake_q    <= wake_nx;
      if (mask_we) mask_q <= mask_wd;
      if (blk_we)  blk_q  <= blk_wd;
      if (take) begin
        acc_code  <= take_code;
        acc_level <= take_lvl;
        blk_q     <= 1'b1;
        mask_q    <= mask_after(auto_en, take_lvl, mask_q);
      end
    end
  end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_accept_pkg::*;
#(
  parameter int N_SRC     = 8,
  parameter int CODE_BASE = 'h200,
  parameter int CODE_STEP = 'h20,
  parameter int NMI_CODE  = 'h1C0,
  localparam int IW       = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_SRC-1:0]       req_vld,
  input  logic [N_SRC*LVL_W-1:0] req_lvl,
  input  logic                   nmi_pin,
  input  logic                   auto_en,
  input  logic                   mai_en,
  input  logic [1:0]             pmode,
  input  logic                   mask_we,
  input  logic [LVL_W-1:0]       mask_wd,
  input  logic                   blk_we,
  input  logic                   blk_wd,
  output logic                   acc_pulse,
  output logic [CODE_W-1:0]      acc_code,
  output logic [ALVL_W-1:0]      acc_level,
  output logic [LVL_W-1:0]       mask_lvl,
  output logic                   blk_state,
  output logic                   wake_req
);
  // Named internal events.
  logic              in_standby;
  logic              pin_gate;
  logic              nmi_pend;
  logic              nmi_fall;
  logic              nmi_take;
  logic              mi_hit;
  logic [IW-1:0]     mi_idx;
  logic [LVL_W-1:0]  mi_lvl;
  logic              mi_take;
  logic              take;
  logic [CODE_W-1:0] take_code;
  logic [ALVL_W-1:0] take_lvl;
  logic              wake_nx;

  assign in_standby = (pmode_e'(pmode) == PM_DEEP);
  assign pin_gate   = mai_en & ~nmi_pin;

  irq_nmi_edge u_nmi (
    .clk  (clk),
    .rst  (rst),
    .pin  (nmi_pin),
    .take (nmi_take),
    .pend (nmi_pend),
    .fall (nmi_fall)
  );

  irq_prio_pick #(.N_SRC(N_SRC), .LW(LVL_W)) u_pick (
    .vld   (req_vld),
    .lvls  (req_lvl),
    .mask  (mask_lvl),
    .allow (~blk_state & ~pin_gate),
    .hit   (mi_hit),
    .idx   (mi_idx),
    .lvl   (mi_lvl)
  );

  assign nmi_take = nmi_pend & ~in_standby;
  assign mi_take  = mi_hit & ~in_standby & ~nmi_take;
  assign take     = nmi_take | mi_take;

  always_comb begin
    if (nmi_take) begin
      take_code = CODE_W'(NMI_CODE);
      take_lvl  = NMI_LEVEL;
    end else begin
      take_code = src_code(CODE_BASE, CODE_STEP, int'(mi_idx));
      take_lvl  = ALVL_W'(mi_lvl);
    end
  end

  assign wake_nx = in_standby & ~pin_gate & (nmi_pend | mi_hit);

  irq_accept_state u_state (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .take_code (take_code),
    .take_lvl  (take_lvl),
    .auto_en   (auto_en),
    .mask_we   (mask_we),
    .mask_wd   (mask_wd),
    .blk_we    (blk_we),
    .blk_wd    (blk_wd),
    .wake_nx   (wake_nx),
    .acc_pulse (acc_pulse),
    .acc_code  (acc_code),
    .acc_level (acc_level),
    .mask_q    (mask_lvl),
    .blk_q     (blk_state),
    .wake_q    (wake_req)
  );
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk (
  input logic       clk,
  input logic       rst,
  input logic       acc_pulse,
  input logic [4:0] acc_level,
  input logic [3:0] mask_lvl,
  input logic       blk_state,
  input logic       wake_req,
  input logic       auto_en,
  input logic       mai_en,
  input logic       nmi_pin,
  input logic [1:0] pmode
);
  p_blocked_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_pulse && acc_level <= 5'd15) |-> !$past(blk_state));

  p_above_mask_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_pulse && acc_level <= 5'd15) |-> (acc_level > {1'b0, $past(mask_lvl)}));

  p_never_zero_r3: assert property (@(posedge clk) disable iff (rst)
    acc_pulse |-> (acc_level != 5'd0));

  p_block_set_r6: assert property (@(posedge clk) disable iff (rst)
    acc_pulse |-> blk_state);

  p_auto_mask_r6: assert property (@(posedge clk) disable iff (rst)
    (acc_pulse && $past(auto_en)) |->
      (mask_lvl == ((acc_level > 5'd15) ? 4'd15 : acc_level[3:0])));

  p_pin_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_pulse && acc_level <= 5'd15) |-> !$past(mai_en && !nmi_pin));

  p_standby_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(pmode) == 2'b10) |-> !acc_pulse);

  p_wake_gate_r9: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> ($past(pmode) == 2'b10 && !$past(mai_en && !nmi_pin)));
endmodule

bind irq_accept_unit irq_accept_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .acc_pulse (acc_pulse),
  .acc_level (acc_level),
  .mask_lvl  (mask_lvl),
  .blk_state (blk_state),
  .wake_req  (wake_req),
  .auto_en   (auto_en),
  .mai_en    (mai_en),
  .nmi_pin   (nmi_pin),
  .pmode     (pmode)
);

// File: tb/sim_irq_accept_unit.sv
`timescale 1ns/1ps
module sim_irq_accept_unit;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req_vld = '0;
  logic [N*4-1:0] req_lvl = '0;
  logic         nmi_pin = 1'b1;
  logic         auto_en = 1'b0;
  logic         mai_en = 1'b0;
  logic [1:0]   pmode = 2'b00;
  logic         mask_we = 1'b0;
  logic [3:0]   mask_wd = '0;
  logic         blk_we = 1'b0;
  logic         blk_wd = 1'b0;
  logic         acc_pulse;
  logic [11:0]  acc_code;
  logic [4:0]   acc_level;
  logic [3:0]   mask_lvl;
  logic         blk_state;
  logic         wake_req;

  irq_accept_unit u0 (.*);

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [11:0] code;
    logic [4:0]  lvl;
    logic [3:0]  mask;
    int          due;
    string       tag;
  } exp_t;

  exp_t sb[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic expect_acc(input int code, input int lvl, input int mask,
                            input int dly, input string tag);
    exp_t e;
    e.code = 12'(code); e.lvl = 5'(lvl); e.mask = 4'(mask);
    e.due = cyc + dly; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: pops scoreboard entries as pulses appear.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (acc_pulse) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R2 unexpected acceptance", int'(acc_code), 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(acc_code == e.code, {e.tag, " code"}, int'(acc_code), int'(e.code));
          chk(acc_level == e.lvl, {e.tag, " level"}, int'(acc_level), int'(e.lvl));
          chk(mask_lvl == e.mask, {"R6 mask after ", e.tag}, int'(mask_lvl), int'(e.mask));
          chk(blk_state == 1'b1, "R6 block set", int'(blk_state), 1);
          chk(cyc == e.due, {e.tag, " timing"}, cyc, e.due);
        end
      end else if (sb.size() != 0 && sb[0].due < cyc) begin
        exp_t e;
        e = sb.pop_front();
        chk(1'b0, {e.tag, " missing acceptance"}, 0, 1);
      end
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic sw_write(input bit wm, input int m, input bit wb, input bit b);
    mask_we = wm; mask_wd = 4'(m); blk_we = wb; blk_wd = b;
    tick();
    mask_we = 1'b0; blk_we = 1'b0;
  endtask

  task automatic set_req(input int i, input int l);
    req_vld[i] = 1'b1;
    req_lvl[i*4 +: 4] = 4'(l);
  endtask

  task automatic clr_req();
    req_vld = '0;
    req_lvl = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick();
    // R1 reset state
    chk(acc_pulse == 0, "R1 pulse", int'(acc_pulse), 0);
    chk(mask_lvl == 15, "R1 mask", int'(mask_lvl), 15);
    chk(blk_state == 1, "R1 block", int'(blk_state), 1);
    chk(wake_req == 0, "R1 wake", int'(wake_req), 0);

    // R2: blocked while block state is 1
    sw_write(1, 3, 0, 0);
    set_req(2, 9);
    tick(3);
    chk(acc_pulse == 0, "R2 blocked", int'(acc_pulse), 0);
    clr_req();

    // R11 block write, then R5/R6 automatic mask update
    sw_write(0, 0, 1, 0);
    chk(blk_state == 0, "R11 block write", int'(blk_state), 0);
    chk(mask_lvl == 3, "R11 mask write", int'(mask_lvl), 3);
    auto_en = 1'b1;
    set_req(2, 9);
    expect_acc('h240, 9, 9, 1, "R5 source 2");
    tick(); clr_req(); tick(3);
    chk(acc_code == 12'h240, "R10 code held", int'(acc_code), 'h240);
    chk(acc_level == 5'd9, "R10 level held", int'(acc_level), 9);

    // R4 tie goes to lowest index, automatic update off
    auto_en = 1'b0;
    sw_write(1, 2, 1, 0);
    set_req(1, 7); set_req(5, 7); set_req(3, 4);
    expect_acc('h220, 7, 2, 1, "R4 tie");
    tick(); clr_req(); tick();

    // R4 highest level wins over lower index
    sw_write(0, 0, 1, 0);
    set_req(0, 3); set_req(6, 12);
    expect_acc('h2C0, 12, 2, 1, "R4 highest");
    tick(); clr_req(); tick();

    // R3 level equal to mask is refused, one above is taken
    sw_write(1, 7, 1, 0);
    set_req(4, 7);
    tick(2);
    chk(blk_state == 0, "R3 equal refused", int'(blk_state), 0);
    set_req(4, 8);
    expect_acc('h280, 8, 7, 1, "R3 above mask");
    tick(); clr_req(); tick();

    // R3 level 0 never accepted
    sw_write(1, 0, 1, 0);
    set_req(7, 0);
    tick(2);
    chk(blk_state == 0, "R3 level zero refused", int'(blk_state), 0);
    clr_req();

    // R8 NMI taken under pin gate; R7 maskable held off while pin low
    auto_en = 1'b1;
    mai_en = 1'b1;
    nmi_pin = 1'b0;
    set_req(3, 10);
    expect_acc('h1C0, 16, 15, 2, "R8 nmi");
    tick(3);
    sw_write(1, 0, 1, 0);
    tick(3);
    chk(blk_state == 0, "R7 maskable gated", int'(blk_state), 0);
    chk(acc_pulse == 0, "R7 no pulse", int'(acc_pulse), 0);
    nmi_pin = 1'b1;
    expect_acc('h260, 10, 10, 1, "R7 released");
    tick(); clr_req(); tick(2);

    // R8 NMI ignores block state, accepted once
    mai_en = 1'b0;
    nmi_pin = 1'b0;
    expect_acc('h1C0, 16, 15, 2, "R8 nmi while blocked");
    tick(5);
    nmi_pin = 1'b1;
    tick(2);

    // R7 sleep mode with pin high accepts normally
    pmode = 2'b01;
    mai_en = 1'b1;
    sw_write(1, 0, 1, 0);
    set_req(5, 6);
    expect_acc('h2A0, 6, 6, 1, "R7 sleep");
    tick(); clr_req(); tick();

    // R9 standby with pin gate: no wake while low
    pmode = 2'b10;
    sw_write(1, 0, 1, 0);
    nmi_pin = 1'b0;
    tick(3);
    chk(wake_req == 0, "R9 wake gated", int'(wake_req), 0);
    chk(acc_pulse == 0, "R9 standby no pulse", int'(acc_pulse), 0);
    nmi_pin = 1'b1;
    tick();
    chk(wake_req == 1, "R9 wake after release", int'(wake_req), 1);
    pmode = 2'b00;
    expect_acc('h1C0, 16, 15, 1, "R9 nmi after wake");
    tick();
    chk(wake_req == 0, "R9 wake drops", int'(wake_req), 0);
    tick();

    // R9 standby without gate: wake two edges after fall
    mai_en = 1'b0;
    pmode = 2'b10;
    sw_write(1, 0, 1, 0);
    nmi_pin = 1'b0;
    tick(2);
    chk(wake_req == 1, "R9 nmi wake", int'(wake_req), 1);
    nmi_pin = 1'b1;
    pmode = 2'b00;
    expect_acc('h1C0, 16, 15, 1, "R9 nmi taken");
    tick(2);

    // R9 maskable request wakes standby without acceptance
    pmode = 2'b10;
    sw_write(1, 0, 1, 0);
    set_req(2, 3);
    tick();
    chk(wake_req == 1, "R9 maskable wake", int'(wake_req), 1);
    chk(blk_state == 0, "R9 nothing taken", int'(blk_state), 0);
    clr_req();
    pmode = 2'b00;
    tick(3);

    chk(sb.size() == 0, "R8 scoreboard drained", sb.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule